// File: doc/BRIEF.md
# Frame-to-Client De-mapper

This block takes a stream of server frames, one slot per clock, and recovers the client data carried inside them. Every frame opens with a short group of overhead slots that hold a count, Cn, the number of client entities the frame carries. After the overhead come a fixed number of payload slots. Cn controls two things: which payload slots hold client data (the rest are stuff and are dropped) and how fast the client side reads data back out. The server and client rates are not tied together, so the client read timing comes only from the server clock and the received Cn. It is never taken from any client-side timing.

A framing controller runs in three states. HUNT waits for a frame start. OVERHEAD gathers the count bytes. PAYLOAD walks the payload slots. The transitions are: any state to OVERHEAD on a frame start; OVERHEAD to PAYLOAD on the first slot without the overhead marker; PAYLOAD to HUNT after the last payload slot, or on a stray overhead marker. Selected payload entities go into a small buffer. A phase-accumulator rate generator, clocked by the server clock, issues read strobes that spread the Cn reads of each frame evenly over the frame. An output controller has two states. FILL holds the output quiet. RUN lets strobes pop data. The change from FILL to RUN happens once after reset, when the buffer first reaches half full.

Top module: `frame_client_demapper`

## Requirements
- R1: Cn is the big-endian value built from the overhead slots of a frame. With the default parameters this is 2 slots of 8 bits, the first slot being the upper byte. The first overhead slot is marked by `srv_sof`, and every overhead slot is marked by `srv_oh`. The value applies to the payload slots of the same frame.
- R2: Payload slot j, counted from 0 after the overhead, is client data exactly when (j·Cn) mod P < Cn, where P is the payload slot count (6 by default). Client data leaves on `clt_data` in arrival order, and stuff slots never reach the output.
- R3: If the received Cn exceeds P, `frm_err` pulses high for one cycle, in the cycle after the first payload slot. Slot selection and the client rate then use the last accepted Cn, which is 0 after reset. `frm_err` stays low for every frame whose Cn is at most P.
- R4: The rate generator adds the accepted Cn on every clock and fires each time its sum reaches the frame length L = overhead slots + P (8 by default), keeping the remainder. With Cn held constant and the buffer never empty, every 8 frames produce exactly 8·Cn client outputs.
- R5: `clt_valid` stays low until the buffer has held at least half its depth (8 of 16 by default) once since reset. From then on, output is enabled for good.
- R6: During and right after reset, `clt_valid` and `frm_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Server clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| srv_sof | input | 1 | Marks the first overhead slot of a frame |
| srv_oh | input | 1 | Marks every overhead slot |
| srv_data | input | W | Server slot content |
| clt_data | output | W | Recovered client entity |
| clt_valid | output | 1 | `clt_data` holds a client entity this cycle |
| frm_err | output | 1 | One-cycle flag for a frame with an out-of-range count |

## Verification
The selection phase is kept as a running value. If it goes wrong, a stuff byte lands in the buffer or a data byte is dropped, and this breaks the incrementing client sequence at its next read, usually within one frame. If the rate accumulator or the held Cn goes wrong, the number of outputs in an 8-frame window no longer matches 8·Cn, and the count check over that window shows it. If the output controller goes wrong, `clt_valid` rises before the half-full point, which the first frame shows because it cannot supply half a buffer on its own.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_OVERHEAD = 2'd1,
        ST_PAYLOAD  = 2'd2
    } frame_state_t;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } out_state_t;
endpackage

// File: rtl/fcd_slot_ctrl.sv
module fcd_slot_ctrl
    import fcd_pkg::*;
#(
    parameter int W        = 8,
    parameter int OH_SLOTS = 2,
    parameter int P        = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sof,
    input  logic            oh,
    input  logic [W-1:0]    din,
    output logic            wr_en,
    output logic [W-1:0]    wr_data,
    output logic [$clog2(P+1)-1:0] cn_cur,
    output logic            frm_err
);
    localparam int CNW = OH_SLOTS * W;
    localparam int CW  = $clog2(P + 1);

    frame_state_t    state, state_nx;
    logic [CNW-1:0]  oh_sr;
    logic [CW-1:0]   sel_acc;
    logic [CW-1:0]   pay_idx;

    logic            first_pay;
    logic            cn_ok;
    logic [CW-1:0]   cn_eff;
    logic            in_pay;
    logic [CW-1:0]   phase;
    logic [CW:0]     phase_sum;
    logic [CW-1:0]   phase_nx;

    always_comb begin
        first_pay = (state == ST_OVERHEAD) && !oh && !sof;
        cn_ok     = (oh_sr <= CNW'(P));
        cn_eff    = (first_pay && cn_ok) ? oh_sr[CW-1:0] : cn_cur;
        in_pay    = first_pay ||
                    ((state == ST_PAYLOAD) && !oh && !sof && (pay_idx < CW'(P)));
        phase     = first_pay ? '0 : sel_acc;
        phase_sum = {1'b0, phase} + {1'b0, cn_eff};
        phase_nx  = (phase_sum >= (CW+1)'(P)) ? CW'(phase_sum - (CW+1)'(P))
                                              : phase_sum[CW-1:0];
        wr_en     = in_pay && (phase < cn_eff);
        wr_data   = din;
    end

    always_comb begin
        state_nx = state;
        if (sof) begin
            state_nx = ST_OVERHEAD;
        end else begin
            unique case (state)
                ST_HUNT:     state_nx = ST_HUNT;
                ST_OVERHEAD: if (!oh) state_nx = (P == 1) ? ST_HUNT : ST_PAYLOAD;
                ST_PAYLOAD:  if (oh || (in_pay && pay_idx == CW'(P - 1)))
                                 state_nx = ST_HUNT;
                default:     state_nx = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oh_sr   <= '0;
            sel_acc <= '0;
            pay_idx <= '0;
            cn_cur  <= '0;
            frm_err <= 1'b0;
        end else begin
            frm_err <= first_pay && !cn_ok;
            if (sof) begin
                oh_sr <= CNW'(din);
            end else if (state == ST_OVERHEAD && oh) begin
                oh_sr <= (oh_sr << W) | CNW'(din);
            end
            if (first_pay) cn_cur <= cn_eff;
            if (in_pay) begin
                sel_acc <= phase_nx;
                pay_idx <= first_pay ? CW'(1) : pay_idx + CW'(1);
            end
        end
    end

    AST_CN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cn_cur <= CW'(P)); // R3
    AST_ERR_KEEPS_CN: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err |-> $stable(cn_cur)); // R3
    AST_WR_NOT_OH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAYLOAD && wr_en) |-> $past(state != ST_HUNT)); // R2
endmodule

// File: rtl/fcd_buffer.sv
module fcd_buffer #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [W-1:0]             wdata,
    input  logic                     rd,
    output logic [W-1:0]             rdata,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_wr, do_rd;

    always_comb begin
        full  = (level == (AW+1)'(DEPTH));
        empty = (level == '0);
        do_wr = wr && !full;
        do_rd = rd && !empty;
        rdata = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            level <= level + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr); // R2
    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (level <= $past(level) + 1)); // R2
endmodule

// File: rtl/fcd_rate_gen.sv
module fcd_rate_gen #(
    parameter int OH_SLOTS = 2,
    parameter int P        = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(P+1)-1:0] cn,
    output logic                   fire
);
    localparam int CW = $clog2(P + 1);
    localparam int L  = OH_SLOTS + P;
    localparam int RW = $clog2(L + P + 1);

    logic [RW-1:0] acc;
    logic [RW-1:0] sum;

    always_comb sum = acc + RW'(cn);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= (sum >= RW'(L));
            acc  <= (sum >= RW'(L)) ? sum - RW'(L) : sum;
        end
    end

    AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        acc < RW'(L)); // R4
    AST_NO_FIRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cn) == '0 && $past(acc) < RW'(L)) |-> !fire); // R4
endmodule

// File: rtl/frame_client_demapper.sv
module frame_client_demapper
    import fcd_pkg::*;
#(
    parameter int W        = 8,
    parameter int OH_SLOTS = 2,
    parameter int P        = 6,
    parameter int DEPTH    = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srv_sof,
    input  logic         srv_oh,
    input  logic [W-1:0] srv_data,
    output logic [W-1:0] clt_data,
    output logic         clt_valid,
    output logic         frm_err
);
    localparam int CW   = $clog2(P + 1);
    localparam int LW   = $clog2(DEPTH) + 1;
    localparam int HALF = DEPTH / 2;

    logic          wr_en;
    logic [W-1:0]  wr_data;
    logic [CW-1:0] cn_cur;
    logic          fire;
    logic [W-1:0]  rdata;
    logic          empty;
    logic [LW-1:0] level;
    logic          pop;
    out_state_t    ostate, ostate_nx;

    fcd_slot_ctrl #(.W(W), .OH_SLOTS(OH_SLOTS), .P(P)) u_slot (
        .clk(clk), .rst_n(rst_n), .sof(srv_sof), .oh(srv_oh), .din(srv_data),
        .wr_en(wr_en), .wr_data(wr_data), .cn_cur(cn_cur), .frm_err(frm_err)
    );

    fcd_buffer #(.W(W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr(wr_en), .wdata(wr_data),
        .rd(pop), .rdata(rdata), .empty(empty), .level(level)
    );

    fcd_rate_gen #(.OH_SLOTS(OH_SLOTS), .P(P)) u_rate (
        .clk(clk), .rst_n(rst_n), .cn(cn_cur), .fire(fire)
    );

    always_comb begin
        ostate_nx = ostate;
        unique case (ostate)
            ST_FILL: if (level >= LW'(HALF)) ostate_nx = ST_RUN;
            ST_RUN:  ostate_nx = ST_RUN;
            default: ostate_nx = ST_FILL;
        endcase
        pop = fire && (ostate == ST_RUN) && !empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ostate <= ST_FILL;
        else        ostate <= ostate_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clt_valid <= 1'b0;
            clt_data  <= '0;
        end else begin
            clt_valid <= pop;
            if (pop) clt_data <= rdata;
        end
    end

    AST_VALID_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        clt_valid |-> $past(ostate == ST_RUN)); // R5
    AST_VALID_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        clt_valid |-> $past(fire)); // R4
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ostate == ST_RUN) |-> (ostate == ST_RUN)); // R5
endmodule

// File: tb/tb_frame_client_demapper.sv
`timescale 1ns/1ps
module tb_frame_client_demapper;
    localparam int W = 8, OHS = 2, P = 6, DEPTH = 16;
    localparam int L = OHS + P;
    localparam int HALF = DEPTH / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         srv_sof = 1'b0, srv_oh = 1'b0;
    logic [W-1:0] srv_data = '0;
    logic [W-1:0] clt_data;
    logic         clt_valid, frm_err;

    int compared = 0, mismatched = 0;
    int fed = 0, out_cnt = 0, err_cnt = 0;
    int next_val = 0, exp_val = 0;
    bit first_seen = 1'b0, done = 1'b0;

    always #5 clk = ~clk;

    frame_client_demapper #(.W(W), .OH_SLOTS(OHS), .P(P), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .srv_sof(srv_sof), .srv_oh(srv_oh),
        .srv_data(srv_data), .clt_data(clt_data), .clt_valid(clt_valid),
        .frm_err(frm_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (frm_err) err_cnt++;
            if (clt_valid) begin
                if (!first_seen) begin
                    first_seen = 1'b1;
                    // R5: output may only start after half a buffer was supplied
                    check(fed >= HALF, "R5 first output before half full", fed, HALF);
                end
                // R2: client sequence is contiguous, no stuff byte, no loss
                check(clt_data == W'(exp_val), "R2 client data order", clt_data, exp_val & 255);
                exp_val++;
                out_cnt++;
            end
        end
    end

    task automatic slot(input bit s, input bit o, input logic [W-1:0] d);
        @(posedge clk);
        #1;
        srv_sof  = s;
        srv_oh   = o;
        srv_data = d;
    endtask

    // field: value in the overhead; sel: count that really governs the frame
    task automatic send_frame(input int field, input int sel);
        slot(1'b1, 1'b1, W'(field >> 8));
        slot(1'b0, 1'b1, W'(field));
        for (int j = 0; j < P; j++) begin
            if (((j * sel) % P) < sel) begin
                slot(1'b0, 1'b0, W'(next_val));
                next_val++;
                fed++;
            end else begin
                slot(1'b0, 1'b0, W'(8'hA5 ^ j));
            end
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int snap, errs;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(clt_valid == 1'b0, "R6 clt_valid in reset", clt_valid, 0);
        check(frm_err == 1'b0, "R6 frm_err in reset", frm_err, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(clt_valid == 1'b0 && frm_err == 1'b0, "R6 outputs after reset", {clt_valid, frm_err}, 0);

        // R5: one frame of 6 cannot fill half the buffer, so nothing comes out
        send_frame(6, 6);
        @(negedge clk);
        check(out_cnt == 0, "R5 output held during fill", out_cnt, 0);
        send_frame(6, 6);

        // R1 R2 R4: sweep every legal count
        for (int cn = P; cn >= 0; cn--) begin
            repeat (4) send_frame(cn, cn);
            snap = out_cnt;
            repeat (8) send_frame(cn, cn);
            check(out_cnt - snap == 8 * cn, "R4 outputs per 8 frames", out_cnt - snap, 8 * cn);
        end

        repeat (4) send_frame(3, 3);
        // R3: out-of-range counts keep the last accepted count (3)
        errs = err_cnt;
        snap = out_cnt;
        send_frame(7, 3);
        send_frame(3, 3);
        send_frame(16'h0103, 3);
        send_frame(3, 3);
        send_frame(16'hFFFF, 3);
        repeat (3) send_frame(3, 3);
        check(out_cnt - snap == 8 * 3, "R3 rate kept after bad count", out_cnt - snap, 24);
        check(err_cnt - errs == 3, "R3 error pulses", err_cnt - errs, 3);

        // R1: upper overhead byte counts, 0x0100 is out of range
        errs = err_cnt;
        send_frame(16'h0100, 3);
        send_frame(P, P);
        check(err_cnt - errs == 1, "R1 upper overhead byte used", err_cnt - errs, 1);

        repeat (6) send_frame(2, 2);
        check(err_cnt == 4, "R3 no error on legal frames", err_cnt, 4);
        check(exp_val <= next_val, "R2 no extra outputs", exp_val, next_val);
        check(next_val - exp_val <= DEPTH, "R2 buffer backlog bounded", next_val - exp_val, DEPTH);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule